// File: doc/BRIEF.md
# Sector Erase Launcher and Completion Poller

This block sits on the host side of a parallel flash bus. It takes a sector erase request from the system, issues the six-write command sequence that starts the erase, and then lets go of the bus. From then on it returns at a fixed interval to ask whether the erase has finished. Once a device has begun an erase it no longer latches addresses, so the block keeps the requested sector address in a register for the whole operation. It drives that same address on every status read and on every re-issue of the sequence.

Completion comes from one of two sources, chosen by a parameter. In data-poll mode the block performs a read strobe at the saved sector address and watches the top status bit of the returned byte. In pin mode it leaves the bus idle and samples a busy/ready input instead. A limit on the number of polls turns an erase that never finishes into an error result. If the system reports that the device was reset while the erase was pending, the block issues the whole sequence again for the same sector.

The request and the result are both valid/ready channels. A request is taken only in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` stays low until the result has been consumed. The result is presented with `done_valid`. While `done_ready` is low, the result and its flags stay frozen, so a stalled consumer loses nothing.

Top module: `erase_poller`

## Requirements
- R1: After reset the block is idle. `req_ready` is 1, `done_valid` is 0, and `bus_ce_n`, `bus_we_n` and `bus_oe_n` are all 1.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the result has been taken.
- R3: In the cycle after acceptance, the block starts six bus writes. Each write holds `bus_ce_n` and `bus_we_n` low for one cycle and is followed by one cycle with both high. The address/data pairs are 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h and then the sector address/30h.
- R4: The sixth write, every status read, and the `done_addr` result all carry the exact sector address that was accepted with the request.
- R5: Whenever `bus_ce_n` is 1, `bus_addr` and `bus_wdata` are 0. Between polls the bus stays released for POLL_GAP cycles.
- R6: In data-poll mode (USE_BUSY_PIN=0), each poll is a one-cycle read with `bus_ce_n` and `bus_oe_n` low. The erase counts as complete when `bus_rdata[7]` is 1 at the end of that cycle.
- R7: In pin mode (USE_BUSY_PIN=1), `bus_oe_n` never goes low. Each poll samples `bus_ready`, where 1 means done and 0 means busy.
- R8: If MAX_POLLS polls all report busy, the result is issued with `done_err`=1. A result that follows a poll reporting done has `done_err`=0.
- R9: While `done_valid` is 1 and `done_ready` is 0, `done_valid`, `done_err` and `done_addr` hold their values.
- R10: A pulse on `dev_abort` while the block is waiting on the erase restarts the full six-write sequence to the saved address and resets the poll count. A pulse on `dev_abort` while the block is idle has no effect.
- R11: Take the acceptance edge as edge 0. Poll k (counting from 0) is sampled on edge 13+POLL_GAP+k·(POLL_GAP+1), and `done_valid` rises on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Any address inside the sector to erase |
| done_valid | output | 1 | Result present |
| done_ready | input | 1 | Consumer takes the result |
| done_err | output | 1 | 1 when the poll limit ran out |
| done_addr | output | ADDR_W | Sector address of the finished erase |
| dev_abort | input | 1 | Device was reset during the erase; restart it |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data from the device |
| bus_ready | input | 1 | Busy/ready from the device, 1 when done |

## Verification
The assertions check on every cycle that:
- the write strobe never appears without chip enable, and the read and write strobes never overlap;
- a released bus carries zeros;
- the stored sector address cannot change mid-operation;
- an accepted request is followed at once by the first unlock write;
- a stalled result stays frozen;
- pin mode never strobes a read.

Other behaviour depends on how the device responds over time, so only the bench scenarios can show it. This covers the exact poll timing against the device's busy duration, the boundary between the last successful poll and a timeout, the number of reads issued, and the full re-issue of the sequence after an abort.

// File: rtl/ep_pkg.sv
package ep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WLO,
    ST_WHI,
    ST_GAP,
    ST_RD,
    ST_DONE
  } ep_state_t;

  localparam int SEQ_LEN = 6;
  localparam int IDX_W   = $clog2(SEQ_LEN);

  localparam logic [7:0] CMD_KEY_A  = 8'hAA;
  localparam logic [7:0] CMD_KEY_B  = 8'h55;
  localparam logic [7:0] CMD_ARM    = 8'h80;
  localparam logic [7:0] CMD_SECTOR = 8'h30;

  localparam int KEY_ADDR_A = 'h555;
  localparam int KEY_ADDR_B = 'h2AA;
endpackage

// File: rtl/ep_cmd_rom.sv
module ep_cmd_rom
  import ep_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] sector_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam logic [ADDR_W-1:0] A_KEY_A = ADDR_W'(KEY_ADDR_A);
  localparam logic [ADDR_W-1:0] A_KEY_B = ADDR_W'(KEY_ADDR_B);

  always_comb begin
    wr_addr = A_KEY_A;
    wr_data = DATA_W'(CMD_KEY_A);
    case (idx)
      IDX_W'(0): begin wr_addr = A_KEY_A;     wr_data = DATA_W'(CMD_KEY_A);  end
      IDX_W'(1): begin wr_addr = A_KEY_B;     wr_data = DATA_W'(CMD_KEY_B);  end
      IDX_W'(2): begin wr_addr = A_KEY_A;     wr_data = DATA_W'(CMD_ARM);    end
      IDX_W'(3): begin wr_addr = A_KEY_A;     wr_data = DATA_W'(CMD_KEY_A);  end
      IDX_W'(4): begin wr_addr = A_KEY_B;     wr_data = DATA_W'(CMD_KEY_B);  end
      default:   begin wr_addr = sector_addr; wr_data = DATA_W'(CMD_SECTOR); end
    endcase
  end
endmodule

// File: rtl/ep_gap_timer.sv
module ep_gap_timer #(
  parameter int GAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic expired
);
  localparam int GW = (GAP < 2) ? 1 : $clog2(GAP);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= GW'(GAP - 1);
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/ep_attempt_ctr.sv
module ep_attempt_ctr #(
  parameter int MAX_POLLS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(MAX_POLLS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = (cnt_q == CW'(MAX_POLLS - 1));
endmodule

// File: rtl/erase_poller.sv
module erase_poller
  import ep_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int STATUS_BIT   = 7,
  parameter int POLL_GAP     = 3,
  parameter int MAX_POLLS    = 8,
  parameter bit USE_BUSY_PIN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              done_valid,
  input  logic              done_ready,
  output logic              done_err,
  output logic [ADDR_W-1:0] done_addr,
  input  logic              dev_abort,
  output logic              bus_ce_n,
  output logic              bus_we_n,
  output logic              bus_oe_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

  ep_state_t         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] saved_q;
  logic              err_q;

  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_data;
  logic              gap_done;
  logic              poll_last;
  logic              erase_done;
  logic              accept;
  logic              restart;
  logic              enter_gap;
  logic              read_phase;

  ep_cmd_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .idx        (idx_q),
    .sector_addr(saved_q),
    .wr_addr    (rom_addr),
    .wr_data    (rom_data)
  );

  generate
    if (USE_BUSY_PIN) begin : g_pin
      assign erase_done = bus_ready;
      assign read_phase = 1'b0;
    end else begin : g_poll
      assign erase_done = bus_rdata[STATUS_BIT];
      assign read_phase = (state_q == ST_RD);
    end
  endgenerate

  logic unused_inputs;
  assign unused_inputs = ^{bus_rdata, bus_ready};

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign restart   = dev_abort && ((state_q == ST_GAP) || (state_q == ST_RD));
  assign enter_gap = !restart &&
                     (((state_q == ST_WHI) && (idx_q == LAST_IDX)) ||
                      ((state_q == ST_RD) && !erase_done && !poll_last));

  ep_gap_timer #(.GAP(POLL_GAP)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (enter_gap),
    .tick   (state_q == ST_GAP),
    .expired(gap_done)
  );

  ep_attempt_ctr #(.MAX_POLLS(MAX_POLLS)) u_att (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept || restart),
    .inc  ((state_q == ST_RD) && !restart),
    .last (poll_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      saved_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            saved_q <= req_addr;
            idx_q   <= '0;
            err_q   <= 1'b0;
            state_q <= ST_WLO;
          end
        end
        ST_WLO: state_q <= ST_WHI;
        ST_WHI: begin
          if (idx_q == LAST_IDX) begin
            state_q <= ST_GAP;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_WLO;
          end
        end
        ST_GAP: begin
          if (restart) begin
            idx_q   <= '0;
            state_q <= ST_WLO;
          end else if (gap_done) begin
            state_q <= ST_RD;
          end
        end
        ST_RD: begin
          if (restart) begin
            idx_q   <= '0;
            state_q <= ST_WLO;
          end else if (erase_done) begin
            err_q   <= 1'b0;
            state_q <= ST_DONE;
          end else if (poll_last) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_GAP;
          end
        end
        ST_DONE: begin
          if (done_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready  = (state_q == ST_IDLE);
    done_valid = (state_q == ST_DONE);
    done_err   = (state_q == ST_DONE) && err_q;
    done_addr  = saved_q;
    bus_we_n   = (state_q != ST_WLO);
    bus_oe_n   = !read_phase;
    bus_ce_n   = !((state_q == ST_WLO) || read_phase);
    bus_addr   = '0;
    bus_wdata  = '0;
    if (state_q == ST_WLO) begin
      bus_addr  = rom_addr;
      bus_wdata = rom_data;
    end else if (read_phase) begin
      bus_addr = saved_q;
    end
  end
endmodule

// File: rtl/erase_poller_chk.sv
module erase_poller_chk #(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter bit USE_BUSY_PIN = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done_valid,
  input logic              done_ready,
  input logic              done_err,
  input logic [ADDR_W-1:0] done_addr,
  input logic              bus_ce_n,
  input logic              bus_we_n,
  input logic              bus_oe_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [ADDR_W-1:0] saved_addr
);
  assert_we_needs_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> !bus_ce_n);

  assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_we_n && !bus_oe_n));

  assert_first_unlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (!bus_we_n && bus_addr == ADDR_W'('h555) && bus_wdata == DATA_W'('hAA)));

  assert_read_addr_saved_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> (bus_addr == saved_addr));

  assert_saved_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(saved_addr) || $past(done_valid && done_ready));

  assert_released_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ce_n |-> (bus_addr == '0 && bus_wdata == '0));

  assert_pin_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    USE_BUSY_PIN |-> bus_oe_n);

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_ready) |=>
      (done_valid && $stable(done_err) && $stable(done_addr)));

  assert_handshake_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && done_valid));
endmodule

bind erase_poller erase_poller_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .USE_BUSY_PIN(USE_BUSY_PIN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done_valid(done_valid),
  .done_ready(done_ready),
  .done_err  (done_err),
  .done_addr (done_addr),
  .bus_ce_n  (bus_ce_n),
  .bus_we_n  (bus_we_n),
  .bus_oe_n  (bus_oe_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .saved_addr(saved_q)
);

// File: tb/erase_poller_tb.sv
module ep_flash_stub #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          dev_rst,
  input  logic [7:0]    busy_len,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          rdy
);
  int          busy_cnt = 0;
  int          wr_count = 0;
  int          rd_count = 0;
  int          rd_bad = 0;
  int          rel_bad = 0;
  logic [AW-1:0] erase_addr = '0;
  logic [AW-1:0] wa [16];
  logic [7:0]    wd [16];

  assign rdy   = (busy_cnt == 0);
  assign rdata = (busy_cnt == 0) ? 8'h80 : 8'h00;

  always @(posedge clk) begin
    if (clr) begin
      wr_count <= 0; rd_count <= 0; rd_bad <= 0; rel_bad <= 0;
    end else begin
      if (!ce_n && !we_n) begin
        if (wr_count < 16) begin
          wa[wr_count] <= addr;
          wd[wr_count] <= wdata;
        end
        wr_count <= wr_count + 1;
      end
      if (!ce_n && !oe_n) begin
        rd_count <= rd_count + 1;
        if (addr != erase_addr) rd_bad <= rd_bad + 1;
      end
      if (ce_n && (addr != '0 || wdata != 8'h00)) rel_bad <= rel_bad + 1;
    end
    if (dev_rst) busy_cnt <= 0;
    else if (!ce_n && !we_n && wdata == 8'h30) begin
      busy_cnt   <= int'(busy_len);
      erase_addr <= addr;
    end else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
  end
endmodule

module erase_poller_tb;
  localparam int AW = 12;
  localparam int G  = 3;
  localparam int MP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;

  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          done_ready = 1'b0;
  logic          dev_abort = 1'b0;
  logic          log_clr = 1'b0;
  logic [7:0]    busy_len = 8'd0;

  logic          d_rr, d_dv, d_de, d_ce, d_we, d_oe, d_rdy;
  logic [AW-1:0] d_da, d_ba;
  logic [7:0]    d_wd, d_rd;
  logic          p_rr, p_dv, p_de, p_ce, p_we, p_oe, p_rdy;
  logic [AW-1:0] p_da, p_ba;
  logic [7:0]    p_wd, p_rd;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  erase_poller #(.ADDR_W(AW), .DATA_W(8), .POLL_GAP(G), .MAX_POLLS(MP),
                 .USE_BUSY_PIN(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(d_rr),
    .req_addr(req_addr), .done_valid(d_dv), .done_ready(done_ready),
    .done_err(d_de), .done_addr(d_da), .dev_abort(dev_abort),
    .bus_ce_n(d_ce), .bus_we_n(d_we), .bus_oe_n(d_oe), .bus_addr(d_ba),
    .bus_wdata(d_wd), .bus_rdata(d_rd), .bus_ready(d_rdy));

  erase_poller #(.ADDR_W(AW), .DATA_W(8), .POLL_GAP(G), .MAX_POLLS(MP),
                 .USE_BUSY_PIN(1'b1)) u_dut_pin (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(p_rr),
    .req_addr(req_addr), .done_valid(p_dv), .done_ready(done_ready),
    .done_err(p_de), .done_addr(p_da), .dev_abort(dev_abort),
    .bus_ce_n(p_ce), .bus_we_n(p_we), .bus_oe_n(p_oe), .bus_addr(p_ba),
    .bus_wdata(p_wd), .bus_rdata(p_rd), .bus_ready(p_rdy));

  ep_flash_stub #(.AW(AW)) s_d (
    .clk(clk), .clr(log_clr), .dev_rst(dev_abort), .busy_len(busy_len),
    .ce_n(d_ce), .we_n(d_we), .oe_n(d_oe), .addr(d_ba), .wdata(d_wd),
    .rdata(d_rd), .rdy(d_rdy));

  ep_flash_stub #(.AW(AW)) s_p (
    .clk(clk), .clr(log_clr), .dev_rst(dev_abort), .busy_len(busy_len),
    .ce_n(p_ce), .we_n(p_we), .oe_n(p_oe), .addr(p_ba), .wdata(p_wd),
    .rdata(p_rd), .rdy(p_rdy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_wa(input int i, input int sec);
    case (i % 6)
      0, 2, 3: return 'h555;
      1, 4:    return 'h2AA;
      default: return sec;
    endcase
  endfunction

  function automatic int exp_wd(input int i);
    case (i % 6)
      0, 3:    return 'hAA;
      1, 4:    return 'h55;
      2:       return 'h80;
      default: return 'h30;
    endcase
  endfunction

  task automatic clear_logs();
    @(negedge clk) log_clr = 1'b1;
    @(negedge clk) log_clr = 1'b0;
  endtask

  task automatic check_writes(input int first, input int sec);
    for (int i = first; i < first + 6; i++) begin
      chk(int'(s_d.wa[i]) == exp_wa(i, sec), "R3 data-mode write addr", int'(s_d.wa[i]), exp_wa(i, sec));
      chk(int'(s_d.wd[i]) == exp_wd(i), "R3 data-mode write byte", int'(s_d.wd[i]), exp_wd(i));
      chk(int'(s_p.wa[i]) == exp_wa(i, sec), "R4 pin-mode write addr", int'(s_p.wa[i]), exp_wa(i, sec));
      chk(int'(s_p.wd[i]) == exp_wd(i), "R3 pin-mode write byte", int'(s_p.wd[i]), exp_wd(i));
    end
  endtask

  task automatic take_result();
    for (int h = 0; h < 2; h++) begin
      @(negedge clk);
      chk(d_dv && p_dv, "R9 done held under back-pressure", int'(d_dv), 1);
    end
    done_ready = 1'b1;
    @(negedge clk) done_ready = 1'b0;
    chk(!d_dv && !p_dv && d_rr && p_rr, "R2 ready returns after result taken", int'(d_rr), 1);
  endtask

  task automatic run_erase(input int sec, input int blen);
    int c0, td, tp, k, s, polls;
    bit exp_err;
    logic dde, pde;
    logic [AW-1:0] dda;
    clear_logs();
    busy_len = 8'(blen);
    @(negedge clk);
    req_addr  = AW'(sec);
    req_valid = 1'b1;
    chk(d_rr && p_rr, "R2 ready before accept", int'(d_rr), 1);
    c0 = cyc;
    @(negedge clk) req_valid = 1'b0;
    req_addr = '0;
    chk(!d_rr && !p_rr, "R2 ready low after accept", int'(d_rr), 0);
    td = -1; tp = -1;
    for (int w = 0; w < 200 && (td < 0 || tp < 0); w++) begin
      @(negedge clk);
      if (d_dv && td < 0) td = cyc - c0 - 1;
      if (p_dv && tp < 0) tp = cyc - c0 - 1;
    end
    k = (blen <= 1 + G) ? 0 : (blen - 1 - G + G) / (G + 1);
    exp_err = (k >= MP);
    if (exp_err) k = MP - 1;
    polls = k + 1;
    s = 13 + G + k * (G + 1);
    chk(td == s, "R11 data-mode done latency", td, s);
    chk(tp == s, "R11 pin-mode done latency", tp, s);
    chk(d_de == exp_err, "R8 data-mode error flag", int'(d_de), int'(exp_err));
    chk(p_de == exp_err, "R8 pin-mode error flag", int'(p_de), int'(exp_err));
    chk(int'(d_da) == sec && int'(p_da) == sec, "R4 done_addr", int'(d_da), sec);
    chk(s_d.wr_count == 6 && s_p.wr_count == 6, "R3 six writes", s_d.wr_count, 6);
    check_writes(0, sec);
    chk(s_d.rd_count == polls, "R6 data-mode read count", s_d.rd_count, polls);
    chk(s_d.rd_bad == 0, "R4 read address matches sector", s_d.rd_bad, 0);
    chk(s_p.rd_count == 0, "R7 pin mode issues no reads", s_p.rd_count, 0);
    chk(s_d.rel_bad == 0 && s_p.rel_bad == 0, "R5 released bus is zero", s_d.rel_bad, 0);
    dde = d_de; pde = p_de; dda = d_da;
    @(negedge clk);
    chk(d_de == dde && p_de == pde && d_da == dda, "R9 result stable", int'(d_da), int'(dda));
    take_result();
  endtask

  initial begin
    int c0, n_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(d_rr && p_rr, "R1 req_ready after reset", int'(d_rr), 1);
    chk(!d_dv && !p_dv, "R1 done_valid after reset", int'(d_dv), 0);
    chk(d_ce && d_we && d_oe && p_ce && p_we && p_oe, "R1 strobes idle",
        int'({d_ce, d_we, d_oe}), 7);

    for (int b = 0; b <= 20; b++) run_erase(('h100 * (b % 15)) + b + 1, b);
    run_erase('hFFF, 16);
    run_erase('hFFF, 17);

    clear_logs();
    @(negedge clk) dev_abort = 1'b1;
    @(negedge clk) dev_abort = 1'b0;
    repeat (4) @(negedge clk);
    chk(s_d.wr_count == 0 && s_p.wr_count == 0, "R10 abort ignored when idle", s_d.wr_count, 0);
    chk(d_rr && p_rr, "R10 still idle after abort", int'(d_rr), 1);

    clear_logs();
    busy_len = 8'd100;
    @(negedge clk) req_addr = AW'('h7A3);
    req_valid = 1'b1;
    c0 = cyc;
    @(negedge clk) req_valid = 1'b0;
    while (cyc < c0 + 20) @(negedge clk);
    n_before = s_d.wr_count;
    chk(n_before == 6, "R10 first sequence before abort", n_before, 6);
    busy_len  = 8'd2;
    dev_abort = 1'b1;
    @(negedge clk) dev_abort = 1'b0;
    for (int w = 0; w < 100 && !(d_dv && p_dv); w++) @(negedge clk);
    chk(d_dv && p_dv, "R10 completes after restart", int'(d_dv), 1);
    chk(!d_de && !p_de, "R10 no error after restart", int'(d_de), 0);
    chk(s_d.wr_count == 12 && s_p.wr_count == 12, "R10 sequence reissued", s_d.wr_count, 12);
    check_writes(6, 'h7A3);
    chk(int'(d_da) == 'h7A3, "R10 address kept", int'(d_da), 'h7A3);
    take_result();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule